// File: doc/BRIEF.md
# Ethernet PHY Power Mode Controller

This block picks the power state of a 10/100 copper transceiver and drives one enable line for each analog or digital sub-block: the receiver, the transmitter, the energy detector, the PLL and the remaining datapath. Its inputs are control bits taken from the management register file, the auto-negotiation enable, the link status and an energy-detect indication. The management logic and the analog circuits sit outside the block. The block only decides the mode and drives the enables.

There are three low-power states. A full power-down is requested by software and keeps only the management interface alive. An energy-detect sleep and a lighter power-saving state are used only while auto-negotiation is on and no link is present. The energy-detect sleep request bit is active low. In that state the PLL can also be shut off automatically. The block also produces a link-pulse tick. Its spacing is counted from a 1 µs tick input, and the spacing becomes longer during energy-detect sleep so that two sleeping partners still see each other's pulses once a cable connects them.

Every output is a plain control level, with no data stream and therefore no handshake. The current mode is brought out as a one-hot status vector.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After reset `mode_oh` is 4'b0001 (normal) and all five enables are 1.
- R2: While `cfg_pdown` is 1, the mode is 4'b1000 (power-down) from the next cycle on, all five enables are 0, and no `lp_tick` occurs after the first power-down cycle. Clearing `cfg_pdown` leaves power-down on the next cycle.
- R3: The energy-detect sleep mode 4'b0100 is requested when `cfg_edpd_n` is 0. It is entered only when `an_en` is 1 and `link_up` is 0. In this mode `rx_en` and `dp_en` are 0, and `tx_en` and `ed_en` are 1.
- R4: In mode 4'b0100, `pll_en` is the inverse of `cfg_pll_auto_off`.
- R5: The power-saving mode 4'b0010 is requested by `cfg_psave` = 1 under the same eligibility as R3. In this mode `rx_en` and `dp_en` are 0, and `tx_en`, `ed_en` and `pll_en` are 1.
- R6: When several modes are requested, power-down wins over energy-detect sleep, which wins over power saving, which wins over normal.
- R7: If `link_up` is 1 or `an_en` is 0, and `cfg_pdown` is 0, the mode is normal on the next cycle.
- R8: `energy_det` = 1 while sleep is eligible and `cfg_pdown` is 0 gives normal mode on the next cycle. If a low-power mode was requested, normal mode is then held until eligibility is lost. Once eligibility returns, the requested mode is entered again.
- R9: Outside mode 4'b0100 (and outside power-down), `lp_tick` pulses once every `NORM_US` ticks of `tick_us`.
- R10: In mode 4'b0100, `lp_tick` pulses once every `NORM_US*STRETCH` ticks.
- R11: `mode_oh` always has exactly one bit set: bit0 normal, bit1 power saving, bit2 energy-detect sleep, bit3 power-down.
- R12: `cfg_pll_auto_off` has no effect on `pll_en` outside mode 4'b0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| cfg_pdown | input | 1 | Power-down request |
| cfg_psave | input | 1 | Power-saving request |
| cfg_edpd_n | input | 1 | Energy-detect sleep request, active low |
| cfg_pll_auto_off | input | 1 | Shut the PLL off during energy-detect sleep |
| an_en | input | 1 | Auto-negotiation enabled |
| link_up | input | 1 | Link is established |
| energy_det | input | 1 | Line energy seen |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| ed_en | output | 1 | Energy detector enable |
| pll_en | output | 1 | PLL enable |
| dp_en | output | 1 | Remaining datapath enable |
| lp_tick | output | 1 | Link-pulse send strobe |
| mode_oh | output | 4 | One-hot current mode |

## Verification
A wrong mode register shows at the ports on the cycle after the inputs that caused it. It appears both in `mode_oh` and in the enable pattern, so mode and enable decode are checked against each other on every cycle. A stuck or missing wake latch shows as a return to sleep one cycle after `energy_det` drops, while eligibility still holds. A wrong interval limit in the pulse counter shows only as a wrong gap between two consecutive `lp_tick` pulses, which is `NORM_US` or `NORM_US*STRETCH` cycles when `tick_us` is held high.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;

  typedef enum logic [3:0] {
    MD_NORM  = 4'b0001,
    MD_PSAVE = 4'b0010,
    MD_EDPD  = 4'b0100,
    MD_PDN   = 4'b1000
  } pwr_mode_e;

  typedef struct packed {
    logic rx;
    logic tx;
    logic ed;
    logic pll;
    logic dp;
  } pwr_en_t;

endpackage

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import phy_pwr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cfg_pdown,
  input  logic      cfg_psave,
  input  logic      cfg_edpd_n,
  input  logic      an_en,
  input  logic      link_up,
  input  logic      energy_det,
  output pwr_mode_e mode
);

  pwr_mode_e mode_d;
  logic      wake_q, wake_d;
  logic      eligible, low_req, awake;

  // sleep is allowed only with auto-negotiation on and no partner
  assign eligible = an_en & ~link_up;
  assign low_req  = ~cfg_edpd_n | cfg_psave;
  assign awake    = wake_q | energy_det;

  always_comb begin
    wake_d = ~cfg_pdown & eligible & (wake_q | (energy_det & low_req));
    if (cfg_pdown)
      mode_d = MD_PDN;
    else if (eligible && !awake) begin
      if (!cfg_edpd_n)     mode_d = MD_EDPD;
      else if (cfg_psave)  mode_d = MD_PSAVE;
      else                 mode_d = MD_NORM;
    end else
      mode_d = MD_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode   <= MD_NORM;
      wake_q <= 1'b0;
    end else begin
      mode   <= mode_d;
      wake_q <= wake_d;
    end
  end

endmodule

// File: rtl/pwr_en_map.sv
module pwr_en_map
  import phy_pwr_pkg::*;
(
  input  pwr_mode_e mode,
  input  logic      pll_auto_off,
  output pwr_en_t   en
);

  always_comb begin
    unique case (mode)
      MD_PSAVE: en = '{rx: 1'b0, tx: 1'b1, ed: 1'b1, pll: 1'b1, dp: 1'b0};
      MD_EDPD:  en = '{rx: 1'b0, tx: 1'b1, ed: 1'b1, pll: ~pll_auto_off, dp: 1'b0};
      MD_PDN:   en = '{rx: 1'b0, tx: 1'b0, ed: 1'b0, pll: 1'b0, dp: 1'b0};
      default:  en = '{rx: 1'b1, tx: 1'b1, ed: 1'b1, pll: 1'b1, dp: 1'b1};
    endcase
  end

endmodule

// File: rtl/lnk_pulse_tmr.sv
module lnk_pulse_tmr #(
  parameter int NORM_US = 16000,
  parameter int STRETCH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_us,
  input  logic hold,
  input  logic stretch_on,
  output logic lp_tick
);

  localparam int LONG_US = NORM_US * STRETCH;
  localparam int CW      = $clog2(LONG_US + 1);

  logic [CW-1:0] cnt_q, lim;
  logic          long_q;

  assign lim = stretch_on ? CW'(LONG_US - 1) : CW'(NORM_US - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      long_q  <= 1'b0;
      lp_tick <= 1'b0;
    end else begin
      long_q  <= stretch_on;
      lp_tick <= 1'b0;
      if (hold || (stretch_on != long_q))
        cnt_q <= '0;
      else if (tick_us) begin
        if (cnt_q >= lim) begin
          cnt_q   <= '0;
          lp_tick <= 1'b1;
        end else
          cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int NORM_US = 16000,
  parameter int STRETCH = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_us,
  input  logic       cfg_pdown,
  input  logic       cfg_psave,
  input  logic       cfg_edpd_n,
  input  logic       cfg_pll_auto_off,
  input  logic       an_en,
  input  logic       link_up,
  input  logic       energy_det,
  output logic       rx_en,
  output logic       tx_en,
  output logic       ed_en,
  output logic       pll_en,
  output logic       dp_en,
  output logic       lp_tick,
  output logic [3:0] mode_oh
);

  pwr_mode_e mode;
  pwr_en_t   en;

  pwr_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_pdown  (cfg_pdown),
    .cfg_psave  (cfg_psave),
    .cfg_edpd_n (cfg_edpd_n),
    .an_en      (an_en),
    .link_up    (link_up),
    .energy_det (energy_det),
    .mode       (mode)
  );

  pwr_en_map u_map (
    .mode         (mode),
    .pll_auto_off (cfg_pll_auto_off),
    .en           (en)
  );

  lnk_pulse_tmr #(
    .NORM_US (NORM_US),
    .STRETCH (STRETCH)
  ) u_tmr (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_us    (tick_us),
    .hold       (mode == MD_PDN),
    .stretch_on (mode == MD_EDPD),
    .lp_tick    (lp_tick)
  );

  assign rx_en   = en.rx;
  assign tx_en   = en.tx;
  assign ed_en   = en.ed;
  assign pll_en  = en.pll;
  assign dp_en   = en.dp;
  assign mode_oh = mode;

endmodule

// File: rtl/phy_pwr_ctrl_chk.sv
module phy_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_pdown,
  input logic       cfg_pll_auto_off,
  input logic       an_en,
  input logic       link_up,
  input logic       energy_det,
  input logic       rx_en,
  input logic       tx_en,
  input logic       ed_en,
  input logic       pll_en,
  input logic       dp_en,
  input logic       lp_tick,
  input logic [3:0] mode_oh
);

  // R2
  pdown_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_pdown |=> (mode_oh == 4'b1000) && !rx_en && !tx_en && !ed_en && !pll_en && !dp_en);

  // R2
  pdown_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == 4'b1000) && $past(mode_oh == 4'b1000) |-> !lp_tick);

  // R3
  edpd_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == 4'b0100) |-> !rx_en && !dp_en && tx_en && ed_en);

  // R4
  edpd_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == 4'b0100) |-> (pll_en == !cfg_pll_auto_off));

  // R5
  psave_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_oh == 4'b0010) |-> !rx_en && !dp_en && tx_en && ed_en && pll_en);

  // R7
  inelig_norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up || !an_en) && !cfg_pdown |=> (mode_oh == 4'b0001));

  // R8
  energy_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    energy_det && !cfg_pdown |=> (mode_oh == 4'b0001) && rx_en && dp_en);

  // R11
  mode_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_oh) == 1);

endmodule

bind phy_pwr_ctrl phy_pwr_ctrl_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .cfg_pdown        (cfg_pdown),
  .cfg_pll_auto_off (cfg_pll_auto_off),
  .an_en            (an_en),
  .link_up          (link_up),
  .energy_det       (energy_det),
  .rx_en            (rx_en),
  .tx_en            (tx_en),
  .ed_en            (ed_en),
  .pll_en           (pll_en),
  .dp_en            (dp_en),
  .lp_tick          (lp_tick),
  .mode_oh          (mode_oh)
);

// File: tb/phy_pwr_ctrl_bench.sv
`timescale 1ns/1ps
module phy_pwr_ctrl_bench;

  localparam int NUS = 16;
  localparam int STR = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_us = 1'b1;
  logic cfg_pdown = 1'b0, cfg_psave = 1'b0, cfg_edpd_n = 1'b1, cfg_pll_auto_off = 1'b0;
  logic an_en = 1'b1, link_up = 1'b0, energy_det = 1'b0;
  logic rx_en, tx_en, ed_en, pll_en, dp_en, lp_tick;
  logic [3:0] mode_oh;

  int checks = 0;
  int fails = 0;
  logic [3:0] exp_mode = 4'b0001;
  logic       exp_wake = 1'b0;

  always #5 clk = ~clk;

  phy_pwr_ctrl #(.NORM_US(NUS), .STRETCH(STR)) u_phy_pwr_ctrl (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .cfg_pdown(cfg_pdown),
    .cfg_psave(cfg_psave), .cfg_edpd_n(cfg_edpd_n), .cfg_pll_auto_off(cfg_pll_auto_off),
    .an_en(an_en), .link_up(link_up), .energy_det(energy_det),
    .rx_en(rx_en), .tx_en(tx_en), .ed_en(ed_en), .pll_en(pll_en), .dp_en(dp_en),
    .lp_tick(lp_tick), .mode_oh(mode_oh)
  );

  // reference model from R3..R8
  always @(posedge clk) begin
    logic elig, lowreq, nw;
    logic [3:0] nm;
    if (!rst_n) begin
      exp_mode = 4'b0001;
      exp_wake = 1'b0;
    end else begin
      elig   = an_en & ~link_up;
      lowreq = ~cfg_edpd_n | cfg_psave;
      nw     = ~cfg_pdown & elig & (exp_wake | (energy_det & lowreq));
      if (cfg_pdown) nm = 4'b1000;
      else if (elig && !(exp_wake || energy_det))
        nm = !cfg_edpd_n ? 4'b0100 : (cfg_psave ? 4'b0010 : 4'b0001);
      else nm = 4'b0001;
      exp_mode = nm;
      exp_wake = nw;
    end
  end

  function automatic logic [4:0] en_of(logic [3:0] m, logic auto_off);
    case (m)
      4'b0010: return 5'b01110;
      4'b0100: return {3'b011, ~auto_off, 1'b0};
      4'b1000: return 5'b00000;
      default: return 5'b11111;
    endcase
  endfunction

  task automatic chk(string req, logic [3:0] want);
    logic [4:0] got_en, want_en;
    got_en  = {rx_en, tx_en, ed_en, pll_en, dp_en};
    want_en = en_of(want, cfg_pll_auto_off);
    checks++;
    if (mode_oh !== want || got_en !== want_en || $countones(mode_oh) != 1) begin
      fails++;
      $display("FAIL %s mode=%b exp=%b en=%b exp_en=%b", req, mode_oh, want, got_en, want_en);
    end
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // count cycles from one lp_tick to the next
  task automatic gap(string req, int want);
    int n = 0;
    while (!lp_tick && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    do begin @(negedge clk); n++; end while (!lp_tick && n < 1000);
    checks++;
    if (n != want) begin
      fails++;
      $display("FAIL %s lp_gap=%0d exp=%0d", req, n, want);
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seen;
    void'($urandom(32'h5eed_0c17));
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 4'b0001);

    // R9 normal interval
    gap("R9", NUS);

    // R5 power saving, R12 auto-off ignored there
    cfg_psave = 1'b1; cfg_pll_auto_off = 1'b1;
    cyc(1); chk("R5_R12", 4'b0010);
    gap("R9", NUS);

    // R6 sleep over saving, R4 PLL off
    cfg_edpd_n = 1'b0;
    cyc(1); chk("R6_R4", 4'b0100);
    cfg_pll_auto_off = 1'b0;
    @(negedge clk); chk("R3_R4", 4'b0100);
    gap("R10", NUS * STR);

    // R8 energy wake and hold
    energy_det = 1'b1; cyc(1); energy_det = 1'b0;
    chk("R8", 4'b0001);
    cyc(5); chk("R8", 4'b0001);
    link_up = 1'b1; cyc(1); chk("R7", 4'b0001);
    link_up = 1'b0; cyc(1); chk("R8", 4'b0100);

    // R7 auto-negotiation off
    an_en = 1'b0; cyc(1); chk("R7", 4'b0001);
    an_en = 1'b1; cyc(1); chk("R3", 4'b0100);

    // R2 power-down over everything
    cfg_pdown = 1'b1; cyc(1); chk("R2_R6", 4'b1000);
    seen = 0;
    for (int i = 0; i < 3 * NUS; i++) begin @(negedge clk); if (lp_tick) seen++; end
    checks++;
    if (seen != 0) begin fails++; $display("FAIL R2 lp_ticks=%0d exp=0", seen); end
    cfg_pdown = 1'b0; cyc(1); chk("R2", 4'b0100);

    // constrained random against the model (R11 onehot inside chk)
    for (int i = 0; i < 3000; i++) begin
      cfg_pdown        = ($urandom % 10) == 0;
      cfg_psave        = $urandom % 2;
      cfg_edpd_n       = ($urandom % 3) != 0;
      cfg_pll_auto_off = $urandom % 2;
      an_en            = ($urandom % 6) != 0;
      link_up          = ($urandom % 5) == 0;
      energy_det       = ($urandom % 7) == 0;
      tick_us          = $urandom % 2;
      @(negedge clk);
      chk("R11_rand", exp_mode);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule